// File: doc/BRIEF.md
# Streaming-Limited Bus Arbiter

This block decides which of several masters drives a shared address bus. Each master raises its request line. The arbiter answers with a one-hot grant that is held until the granted master reports, through a done strobe, that its transaction is complete. One master slot is the processor core port.

A master that wins the bus may keep it for a bounded number of further back-to-back transactions before anyone else can preempt it. The limit comes from a 2-bit stream count in a small control register. Two disable bits can shorten that run to a single transaction: a global one that applies to every master, and one that applies to the core port only.

The same register holds a core-port enable. It takes its value from a boot-configuration pin while reset is asserted, and keeps the core off the bus until it reads 1. Once set, the enable can only be cleared by another reset.

Top module: `stream_arb`

## Requirements
- R1: The grant vector has at most one bit set in every cycle. A grant bit only rises for a master that was requesting at the preceding clock edge. Grant is 0 after reset.
- R2: While the core-enable field (register bit 0) reads 0, the core master (index `CORE_IDX`) never receives a grant, even when it requests. Other masters are unaffected.
- R3: While reset is asserted, register bit 0 loads from `boot_core_en`. With a 1, the core may win arbitration straight after reset. With a 0, the core wins only after a register write of 1 to bit 0, starting one cycle after that write takes effect.
- R4: Once register bit 0 is 1, writing 0 to it has no effect until the next reset.
- R5: The stream count field (register bits 5:4) with code 1, 2 or 3 lets the owning master complete that many extra transactions after its first one without preemption. The stream ends early when the owner's request is low at the done strobe.
- R6: Stream count code 0 behaves exactly like code 1.
- R7: When the global no-stream field (register bit 1) is 1, every master's tenure ends after one transaction.
- R8: When the core no-stream field (register bit 2) is 1, the core's tenure ends after one transaction, while other masters still stream according to the count.
- R9: When a tenure ends, or when the bus is idle, the next grant goes to the first eligible requester in cyclic order starting from the master after the previous owner. After reset the search begins at master 0.
- R10: The register reads 0x30 with bit 0 equal to `boot_core_en` after reset. Bits 7:6 and 3 read 0 and ignore writes, so writing 0xFF reads back 0x37.
- R11: When the bus is idle, a grant appears at the clock edge after the request is seen. The grant then stays unchanged until a done strobe arrives, even if the request drops. On the done strobe of the last transaction, the grant moves to the next winner or clears at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| boot_core_en | input | 1 | Boot value of the core-enable field, sampled while in reset |
| req | input | N | Per-master request lines |
| done | input | 1 | Current transaction completes at this edge |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| gnt | output | N | One-hot grant |

## Verification
The assertions assume the following about the inputs: `done` is only meaningful while a grant is held, and a requester does not need its request to be high at the moment it is granted. The hold and grant-origin checks therefore only compare the grant against the request and done values sampled at the preceding edge. The stimulus drives all inputs on the falling clock edge. Register writes are made only while the bus is idle, and `done` is either held high for a run of transactions or pulsed, so every edge completes at most one transaction.

// File: rtl/stream_arb_pkg.sv
package stream_arb_pkg;
    localparam int REG_W           = 8;
    localparam int BIT_CORE_EN     = 0;
    localparam int BIT_ALL_NOSTRM  = 1;
    localparam int BIT_CORE_NOSTRM = 2;
    localparam int CNT_LSB         = 4;
    localparam int CNT_W           = 2;

    typedef struct packed {
        logic             core_en;
        logic             all_nostrm;
        logic             core_nostrm;
        logic [CNT_W-1:0] cnt;
    } cfg_t;

    // Reserved code 0 is folded onto code 1.
    function automatic logic [CNT_W-1:0] extra_of(logic [CNT_W-1:0] code);
        return (code == '0) ? CNT_W'(1) : code;
    endfunction
endpackage

// File: rtl/stream_arb_cfg.sv
module stream_arb_cfg
    import stream_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_core_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output cfg_t             cfg,
    output logic [REG_W-1:0] rd_data
);
    cfg_t cfg_d, cfg_q;
    logic unused_rsvd;

    assign unused_rsvd = ^{wr_data[REG_W-1:CNT_LSB+CNT_W], wr_data[CNT_LSB-1:BIT_CORE_NOSTRM+1]};

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            // enable is set-only
            cfg_d.core_en     = cfg_q.core_en | wr_data[BIT_CORE_EN];
            cfg_d.all_nostrm  = wr_data[BIT_ALL_NOSTRM];
            cfg_d.core_nostrm = wr_data[BIT_CORE_NOSTRM];
            cfg_d.cnt         = wr_data[CNT_LSB +: CNT_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.core_en     <= boot_core_en;
            cfg_q.all_nostrm  <= 1'b0;
            cfg_q.core_nostrm <= 1'b0;
            cfg_q.cnt         <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

    always_comb begin
        rd_data                     = '0;
        rd_data[BIT_CORE_EN]        = cfg_q.core_en;
        rd_data[BIT_ALL_NOSTRM]     = cfg_q.all_nostrm;
        rd_data[BIT_CORE_NOSTRM]    = cfg_q.core_nostrm;
        rd_data[CNT_LSB +: CNT_W]   = cfg_q.cnt;
    end
endmodule

// File: rtl/stream_arb_rr.sv
module stream_arb_rr #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  elig,
    input  logic [IW-1:0] last,
    output logic          found,
    output logic [IW-1:0] pick
);
    always_comb begin
        found = 1'b0;
        pick  = last;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = int'(last) + k;
            if (idx >= N) idx = idx - N;
            if (!found && elig[idx]) begin
                found = 1'b1;
                pick  = IW'(idx);
            end
        end
    end
endmodule

// File: rtl/stream_arb_budget.sv
module stream_arb_budget
    import stream_arb_pkg::*;
#(
    parameter int CORE_IDX = 0,
    parameter int IW       = 2
) (
    input  cfg_t             cfg,
    input  logic [IW-1:0]    who,
    output logic             may_stream,
    output logic [CNT_W-1:0] extra
);
    logic is_core;

    assign is_core    = (who == IW'(CORE_IDX));
    assign may_stream = !cfg.all_nostrm && !(is_core && cfg.core_nostrm);
    assign extra      = may_stream ? extra_of(cfg.cnt) : '0;
endmodule

// File: rtl/stream_arb.sv
module stream_arb
    import stream_arb_pkg::*;
#(
    parameter int N        = 4,
    parameter int CORE_IDX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_core_en,
    input  logic [N-1:0]     req,
    input  logic             done,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic [N-1:0]     gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic             busy;
        logic [IW-1:0]    owner;
        logic [CNT_W-1:0] left;
    } st_t;

    st_t              st_d, st_q;
    cfg_t             cfg;
    logic [N-1:0]     elig;
    logic             win_found;
    logic [IW-1:0]    win_idx;
    logic             win_ok, cur_ok;
    logic [CNT_W-1:0] win_extra, cur_extra;
    logic             unused_budget;

    stream_arb_cfg u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_core_en (boot_core_en),
        .wr_en        (reg_we),
        .wr_data      (reg_wdata),
        .cfg          (cfg),
        .rd_data      (reg_rdata)
    );

    always_comb begin
        elig = req;
        if (!cfg.core_en) elig[CORE_IDX] = 1'b0;
    end

    stream_arb_rr #(.N(N), .IW(IW)) u_rr (
        .elig  (elig),
        .last  (st_q.owner),
        .found (win_found),
        .pick  (win_idx)
    );

    stream_arb_budget #(.CORE_IDX(CORE_IDX), .IW(IW)) u_win_budget (
        .cfg        (cfg),
        .who        (win_idx),
        .may_stream (win_ok),
        .extra      (win_extra)
    );

    stream_arb_budget #(.CORE_IDX(CORE_IDX), .IW(IW)) u_cur_budget (
        .cfg        (cfg),
        .who        (st_q.owner),
        .may_stream (cur_ok),
        .extra      (cur_extra)
    );

    assign unused_budget = ^{win_ok, cur_extra};

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (win_found) begin
                st_d.busy  = 1'b1;
                st_d.owner = win_idx;
                st_d.left  = win_extra;
            end
        end else if (done) begin
            if (st_q.left != '0 && req[st_q.owner] && cur_ok) begin
                st_d.left = st_q.left - CNT_W'(1);
            end else if (win_found) begin
                st_d.owner = win_idx;
                st_d.left  = win_extra;
            end else begin
                st_d.busy  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.busy  <= 1'b0;
            st_q.owner <= IW'(N - 1);
            st_q.left  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt = st_q.busy ? (N'(1) << st_q.owner) : '0;
endmodule

// File: rtl/stream_arb_chk.sv
module stream_arb_chk
    import stream_arb_pkg::*;
#(
    parameter int N        = 4,
    parameter int CORE_IDX = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     req,
    input logic             done,
    input logic [REG_W-1:0] reg_rdata,
    input logic [N-1:0]     gnt
);
    assert_one_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    assert_grant_to_requester_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0 && gnt != $past(gnt)) |-> ((gnt & $past(req)) != '0));

    assert_core_holdoff_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[BIT_CORE_EN] |-> !gnt[CORE_IDX]);

    assert_sticky_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[BIT_CORE_EN] |=> reg_rdata[BIT_CORE_EN]);

    assert_hold_until_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0 && !done) |=> (gnt == $past(gnt)));
endmodule

bind stream_arb stream_arb_chk #(.N(N), .CORE_IDX(CORE_IDX)) u_chk (.*);

// File: tb/stream_arb_test.sv
module stream_arb_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       boot_core_en = 1'b1;
    logic [N-1:0] req = '0;
    logic       done = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [N-1:0] gnt;

    int vectors = 0;
    int errors  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stream_arb #(.N(N), .CORE_IDX(0)) uut (
        .clk(clk), .rst_n(rst_n), .boot_core_en(boot_core_en), .req(req),
        .done(done), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .gnt(gnt)
    );

    task automatic check(input string rq, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic do_reset(input bit boot);
        @(negedge clk);
        rst_n = 1'b0; boot_core_en = boot; req = '0; done = 1'b0; reg_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_reg(input logic [7:0] v);
        reg_we = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    function automatic int tenure(int m, int code, bit g, bit c);
        bit ok;
        ok = !g && !(m == 0 && c);
        return ok ? 1 + ((code == 0) ? 1 : code) : 1;
    endfunction

    function automatic int next_owner(int cur, logic [3:0] p, bit en);
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (cur + k) % N;
            if (p[idx] && (idx != 0 || en)) return idx;
        end
        return -1;
    endfunction

    initial begin
        // Reset state, holdoff, sticky enable
        do_reset(1'b0);
        check("R10 reset value boot=0", reg_rdata, 8'h30);
        check("R1 grant idle after reset", {4'h0, gnt}, 8'h00);
        req = 4'b0001;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R2 core held off", {4'h0, gnt}, 8'h00);
        end
        write_reg(8'h31);
        check("R3 no grant on enable edge", {4'h0, gnt}, 8'h00);
        @(negedge clk);
        check("R3 core granted after enable write", {4'h0, gnt}, 8'h01);
        req = '0; done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        write_reg(8'h30);
        check("R4 enable sticky", reg_rdata, 8'h31);

        do_reset(1'b1);
        check("R3 reset value boot=1", reg_rdata, 8'h31);
        write_reg(8'hFF);
        check("R10 reserved bits", reg_rdata, 8'h37);

        // R11 grant hold while done low
        do_reset(1'b1);
        req = 4'b0100;
        @(negedge clk);
        check("R11 grant one edge after request", {4'h0, gnt}, 8'h04);
        for (int i = 0; i < 4; i++) begin
            if (i == 1) req = '0;
            @(negedge clk);
            check("R11 grant held without done", {4'h0, gnt}, 8'h04);
        end
        done = 1'b1;
        @(negedge clk);
        check("R11 release on done", {4'h0, gnt}, 8'h00);
        done = 1'b0;

        // R5 request drop ends stream
        do_reset(1'b1);
        req = 4'b1100; done = 1'b1;
        @(negedge clk);
        check("R9 first winner after reset", {4'h0, gnt}, 8'h04);
        req = 4'b1000;
        @(negedge clk);
        check("R5 stream ends when request drops", {4'h0, gnt}, 8'h08);
        req = '0; done = 1'b0;

        // Stream-count / disable sweep
        for (int code = 0; code < 4; code++) begin
            for (int g = 0; g < 2; g++) begin
                for (int c = 0; c < 2; c++) begin
                    logic [7:0] v;
                    string tag;
                    int owner, remain, total;
                    tag = g ? "R7" : (c ? "R8" : ((code == 0) ? "R6" : "R5"));
                    v = 8'h01 | 8'(g << 1) | 8'(c << 2) | 8'(code << 4);
                    do_reset(1'b1);
                    write_reg(v);
                    check("R10 readback", reg_rdata, v);
                    req = 4'hF; done = 1'b1;
                    owner = 0;
                    remain = tenure(0, code, g[0], c[0]);
                    total = 0;
                    for (int m = 0; m < N; m++) total += tenure(m, code, g[0], c[0]);
                    for (int t = 0; t < 2 * total; t++) begin
                        @(negedge clk);
                        check(tag, {4'h0, gnt}, 8'(1 << owner));
                        remain--;
                        if (remain == 0) begin
                            owner = (owner + 1) % N;
                            remain = tenure(owner, code, g[0], c[0]);
                        end
                    end
                    req = '0; done = 1'b0;
                end
            end
        end

        // Round-robin sweep over all request patterns, core enabled or held off
        for (int b = 0; b < 2; b++) begin
            for (int p = 0; p < 16; p++) begin
                int cur;
                do_reset(b[0]);
                write_reg(8'h32);
                req = 4'(p); done = 1'b1;
                cur = N - 1;
                for (int t = 0; t < 8; t++) begin
                    int nx;
                    nx = next_owner(cur, 4'(p), b[0]);
                    @(negedge clk);
                    if (b == 0 && p[0])
                        check("R2 core excluded in rotation", {4'h0, gnt}, (nx < 0) ? 8'h00 : 8'(1 << nx));
                    else
                        check("R9 rotation order", {4'h0, gnt}, (nx < 0) ? 8'h00 : 8'(1 << nx));
                    if (nx >= 0) cur = nx;
                end
                req = '0; done = 1'b0;
            end
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            vectors++;
            errors++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule